// File: doc/BRIEF.md
# Frame packet sequencer

This block orders the packets that surround video frames on a packetised stream in a frame buffer. Each packet opens with a beat whose low four bits give its kind. On the input side the block throws away control packets. It keeps only the expected-length field they carry. User packets go into a small queue, and image packets have their pixels written into an on-chip pixel store. Frame extent comes only from the start-of-packet and end-of-packet markers. The length announced in a control packet is used only to reject mismatched frames, when that check is enabled.

A drop strobe, held with an image packet's end beat, discards that frame. The user packets that arrived before it stay queued and go out with the next frame that is kept. A kept frame waits in a single spare slot until the output side picks it up. The output side then emits the frame's user packets, then one regenerated control placeholder beat, then a regenerated image header and the pixels. A repeat strobe, given while the output is between frames, sends the last frame again. The repeat carries the placeholder and header but none of the user packets. This lets a frame-rate converter drop and repeat frames without losing or duplicating side-band packets.

Top module: `frame_pkt_sequencer`

## Requirements
- R1: The kind of a packet is decoded from bits [3:0] of its start beat: 0 marks image data, 15 marks control, and every other value marks a user packet.
- R2: A control start beat is always accepted (in_ready high). No control packet beat reaches the output. Bits [LW-1:0] of a control packet's second beat are kept as the expected frame length.
- R3: Every frame sent begins with a placeholder beat of data 0x000F with out_sop and out_eop both high. Next comes an image header beat of data 0x0000 with out_sop high, whatever the input header's upper bits were. The pixels follow in input order, with out_eop on the last one.
- R4: User packets leave unchanged and in arrival order, directly ahead of the placeholder of the next kept frame.
- R5: An image packet whose end beat is accepted with in_drop high is never emitted. The user packets that preceded it are emitted ahead of the next kept frame.
- R6: A repeat strobe given while out_gap is high, once a frame has been sent, resends that frame's placeholder, header and pixels with no user packets. out_gap rises in the cycle after the last beat of any image packet.
- R7: With CHECK_LEN set, a frame whose pixel count differs from the latest expected length is discarded like a dropped frame. Its user packets carry forward as in R5.
- R8: While the user-packet queue is full, in_ready stays low for user-packet beats, and no user beat is lost.
- R9: While a kept frame is waiting in the spare slot, the end beat of the next image packet is stalled (in_ready low) until the output side takes the waiting frame.
- R10: After reset, out_valid is low, out_gap is high and in_ready is high.
- R11: A repeat strobe before any frame has been sent has no effect, and out_valid stays low.
- R12: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | W | Input beat data; bits [3:0] of a start beat give the packet kind |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_drop | input | 1 | Drop strobe, held with the end beat of an image packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | W | Output beat data |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_repeat | input | 1 | Repeat strobe, sampled while out_gap is high |
| out_gap | output | 1 | Output side is between frames and will pick the next one |

## Verification
The bound checker watches four things on every cycle. Output beats must hold under backpressure. A placeholder beat must always be followed by an image header. Control start beats must always be accepted. The output must return to the gap state right after an image packet ends. Some behaviour can only be shown by the directed scenarios, because it concerns whole sequences. That covers carrying user packets over dropped and length-rejected frames, leaving them out of a repeated frame, and ignoring an early repeat strobe. It also covers stalling at a full user queue or an occupied spare slot, and the exact beat order and data of every frame.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;
   localparam logic [3:0] TYPE_IMG = 4'h0;
   localparam logic [3:0] TYPE_CTL = 4'hF;

   typedef enum logic [1:0] {PK_IMG, PK_CTL, PK_USR} pk_class_e;
   typedef enum logic [2:0] {RD_GAP, RD_USR, RD_CTL, RD_HDR, RD_PIX} rd_state_e;

   function automatic pk_class_e classify(input logic [3:0] code);
      if (code == TYPE_IMG) return PK_IMG;
      if (code == TYPE_CTL) return PK_CTL;
      return PK_USR;
   endfunction
endpackage

// File: rtl/fbseq_fifo.sv
module fbseq_fifo #(
   parameter int W     = 17,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign full = (wp - rp) == (AW+1)'(DEPTH);
   assign dout = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp[AW-1:0]] <= din;
   end
endmodule

// File: rtl/fbseq_pixmem.sv
module fbseq_pixmem #(
   parameter int W     = 16,
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [W-1:0]             rdata
);
   logic [W-1:0] mem [DEPTH];

   assign rdata = mem[raddr];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
endmodule

// File: rtl/fbseq_writer.sv
module fbseq_writer
   import fbseq_pkg::*;
#(
   parameter int PIX_DEPTH = 16,
   parameter int USR_DEPTH = 8,
   parameter bit CHECK_LEN = 1'b1,
   localparam int PW = $clog2(PIX_DEPTH) + 1,
   localparam int AW = PW - 1,
   localparam int LW = PW,
   localparam int UW = $clog2(USR_DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [LW-1:0] in_low,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic          in_drop,
   input  logic          u_full,
   output logic          u_push,
   output logic          pix_we,
   output logic [AW-1:0] pix_waddr,
   input  logic          take,
   output logic          spare_valid,
   output logic [PW-1:0] spare_base,
   output logic [LW-1:0] spare_len,
   output logic [UW-1:0] spare_ucnt
);
   pk_class_e     cls_q, cls_now;
   logic          fire, img_eop, len_ok, keep, pix_full, ctl_arm, exp_valid;
   logic [PW-1:0] wr_ptr, wr_base, tail, wr_next;
   logic [LW-1:0] fr_len, exp_len;
   logic [UW-1:0] u_pend;

   always_comb begin
      cls_now  = in_sop ? classify(in_low[3:0]) : cls_q;
      pix_full = (wr_ptr - tail) == PW'(PIX_DEPTH);
      unique case (cls_now)
         PK_USR:  in_ready = !u_full;
         PK_CTL:  in_ready = 1'b1;
         default: in_ready = (in_sop || !pix_full) && (!in_eop || !spare_valid);
      endcase
      fire    = in_valid && in_ready;
      pix_we  = fire && (cls_now == PK_IMG) && !in_sop;
      u_push  = fire && (cls_now == PK_USR);
      img_eop = fire && (cls_now == PK_IMG) && in_eop;
      wr_next = wr_ptr + PW'(pix_we);
      fr_len  = wr_next - wr_base;
      keep    = !in_drop && len_ok;
   end

   assign pix_waddr = wr_ptr[AW-1:0];

   generate
      if (CHECK_LEN) begin : g_len_check
         assign len_ok = !exp_valid || (fr_len == exp_len);
      end else begin : g_len_free
         assign len_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q       <= PK_IMG;
         ctl_arm     <= 1'b0;
         exp_valid   <= 1'b0;
         exp_len     <= '0;
         wr_ptr      <= '0;
         wr_base     <= '0;
         tail        <= '0;
         u_pend      <= '0;
         spare_valid <= 1'b0;
         spare_base  <= '0;
         spare_len   <= '0;
         spare_ucnt  <= '0;
      end else begin
         if (fire && in_sop) cls_q <= cls_now;
         if (fire) ctl_arm <= in_sop && !in_eop && (cls_now == PK_CTL);
         if (fire && ctl_arm && (cls_now == PK_CTL)) begin
            exp_len   <= in_low;
            exp_valid <= 1'b1;
         end
         wr_ptr <= wr_next;
         if (u_push) u_pend <= u_pend + 1'b1;
         if (take) begin
            spare_valid <= 1'b0;
            tail        <= spare_base;
         end
         if (img_eop) begin
            if (keep) begin
               spare_valid <= 1'b1;
               spare_base  <= wr_base;
               spare_len   <= fr_len;
               spare_ucnt  <= u_pend;
               u_pend      <= '0;
               wr_base     <= wr_next;
            end else begin
               wr_ptr <= wr_base;
            end
         end
      end
   end
endmodule

// File: rtl/fbseq_reader.sv
module fbseq_reader
   import fbseq_pkg::*;
#(
   parameter int W         = 16,
   parameter int PIX_DEPTH = 16,
   parameter int USR_DEPTH = 8,
   localparam int PW = $clog2(PIX_DEPTH) + 1,
   localparam int AW = PW - 1,
   localparam int LW = PW,
   localparam int UW = $clog2(USR_DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [W-1:0]  out_data,
   output logic          out_sop,
   output logic          out_eop,
   input  logic          out_repeat,
   output logic          out_gap,
   output logic          take,
   input  logic          spare_valid,
   input  logic [PW-1:0] spare_base,
   input  logic [LW-1:0] spare_len,
   input  logic [UW-1:0] spare_ucnt,
   input  logic [W-1:0]  u_dout,
   input  logic          u_deop,
   output logic          u_pop,
   output logic [AW-1:0] pix_raddr,
   input  logic [W-1:0]  pix_rdata
);
   rd_state_e     st;
   logic [PW-1:0] cur_ptr, last_base;
   logic [LW-1:0] remain, last_len;
   logic [UW-1:0] ucnt;
   logic          u_first, have_last, fire, rep_go;

   always_comb begin
      rep_go    = (st == RD_GAP) && out_repeat && have_last;
      take      = (st == RD_GAP) && !rep_go && spare_valid;
      out_valid = (st != RD_GAP);
      out_gap   = (st == RD_GAP);
      out_data  = '0;
      out_sop   = 1'b0;
      out_eop   = 1'b0;
      unique case (st)
         RD_USR: begin
            out_data = u_dout;
            out_sop  = u_first;
            out_eop  = u_deop;
         end
         RD_CTL: begin
            out_data = W'(TYPE_CTL);
            out_sop  = 1'b1;
            out_eop  = 1'b1;
         end
         RD_HDR: begin
            out_data = W'(TYPE_IMG);
            out_sop  = 1'b1;
            out_eop  = (remain == '0);
         end
         RD_PIX: begin
            out_data = pix_rdata;
            out_eop  = (remain == LW'(1));
         end
         default: ;
      endcase
      fire  = out_valid && out_ready;
      u_pop = fire && (st == RD_USR);
   end

   assign pix_raddr = cur_ptr[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= RD_GAP;
         cur_ptr   <= '0;
         remain    <= '0;
         ucnt      <= '0;
         u_first   <= 1'b1;
         last_base <= '0;
         last_len  <= '0;
         have_last <= 1'b0;
      end else begin
         unique case (st)
            RD_GAP: begin
               if (rep_go) begin
                  cur_ptr <= last_base;
                  remain  <= last_len;
                  st      <= RD_CTL;
               end else if (take) begin
                  last_base <= spare_base;
                  last_len  <= spare_len;
                  have_last <= 1'b1;
                  cur_ptr   <= spare_base;
                  remain    <= spare_len;
                  ucnt      <= spare_ucnt;
                  u_first   <= 1'b1;
                  st        <= (spare_ucnt != '0) ? RD_USR : RD_CTL;
               end
            end
            RD_USR: if (fire) begin
               u_first <= u_deop;
               ucnt    <= ucnt - 1'b1;
               if (ucnt == UW'(1)) st <= RD_CTL;
            end
            RD_CTL: if (fire) st <= RD_HDR;
            RD_HDR: if (fire) st <= (remain == '0) ? RD_GAP : RD_PIX;
            RD_PIX: if (fire) begin
               cur_ptr <= cur_ptr + 1'b1;
               remain  <= remain - 1'b1;
               if (remain == LW'(1)) st <= RD_GAP;
            end
            default: st <= RD_GAP;
         endcase
      end
   end
endmodule

// File: rtl/frame_pkt_sequencer.sv
module frame_pkt_sequencer #(
   parameter int W         = 16,
   parameter int PIX_DEPTH = 16,
   parameter int USR_DEPTH = 8,
   parameter bit CHECK_LEN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   input  logic         in_sop,
   input  logic         in_eop,
   input  logic         in_drop,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         out_sop,
   output logic         out_eop,
   input  logic         out_repeat,
   output logic         out_gap
);
   localparam int PW = $clog2(PIX_DEPTH) + 1;
   localparam int AW = PW - 1;
   localparam int LW = PW;
   localparam int UW = $clog2(USR_DEPTH) + 1;

   generate
      if (PIX_DEPTH < 8 || (1 << AW) != PIX_DEPTH) begin : g_bad_pix
         $error("PIX_DEPTH must be a power of two of at least 8");
      end
      if (USR_DEPTH < 2 || (1 << (UW-1)) != USR_DEPTH) begin : g_bad_usr
         $error("USR_DEPTH must be a power of two of at least 2");
      end
      if (W < LW) begin : g_bad_w
         $error("W must hold a frame length");
      end
   endgenerate

   logic          u_full, u_push, u_pop, u_deop, pix_we, take, spare_valid;
   logic [W-1:0]  u_dout, pix_rdata;
   logic [AW-1:0] pix_waddr, pix_raddr;
   logic [PW-1:0] spare_base;
   logic [LW-1:0] spare_len;
   logic [UW-1:0] spare_ucnt;

   fbseq_writer #(.PIX_DEPTH(PIX_DEPTH), .USR_DEPTH(USR_DEPTH), .CHECK_LEN(CHECK_LEN)) u_wr (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_low(in_data[LW-1:0]), .in_sop(in_sop), .in_eop(in_eop), .in_drop(in_drop),
      .u_full(u_full), .u_push(u_push), .pix_we(pix_we), .pix_waddr(pix_waddr),
      .take(take), .spare_valid(spare_valid), .spare_base(spare_base),
      .spare_len(spare_len), .spare_ucnt(spare_ucnt)
   );

   fbseq_fifo #(.W(W+1), .DEPTH(USR_DEPTH)) u_usr (
      .clk(clk), .rst_n(rst_n), .push(u_push), .din({in_eop, in_data}),
      .pop(u_pop), .dout({u_deop, u_dout}), .full(u_full)
   );

   fbseq_pixmem #(.W(W), .DEPTH(PIX_DEPTH)) u_pix (
      .clk(clk), .we(pix_we), .waddr(pix_waddr), .wdata(in_data),
      .raddr(pix_raddr), .rdata(pix_rdata)
   );

   fbseq_reader #(.W(W), .PIX_DEPTH(PIX_DEPTH), .USR_DEPTH(USR_DEPTH)) u_rd (
      .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .out_repeat(out_repeat), .out_gap(out_gap), .take(take),
      .spare_valid(spare_valid), .spare_base(spare_base), .spare_len(spare_len),
      .spare_ucnt(spare_ucnt), .u_dout(u_dout), .u_deop(u_deop), .u_pop(u_pop),
      .pix_raddr(pix_raddr), .pix_rdata(pix_rdata)
   );
endmodule

// File: rtl/fbseq_chk.sv
module fbseq_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         in_ready,
   input logic [3:0]   in_type,
   input logic         in_sop,
   input logic         out_valid,
   input logic         out_ready,
   input logic [W-1:0] out_data,
   input logic         out_sop,
   input logic         out_eop,
   input logic         out_gap
);
   logic in_img;
   logic ofire;

   assign ofire = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) in_img <= 1'b0;
      else if (ofire && out_sop) in_img <= (out_data[3:0] == 4'h0) && !out_eop;
      else if (ofire && out_eop) in_img <= 1'b0;
   end

   a_r12_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

   a_r3_header_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ofire && out_sop && out_eop && out_data[3:0] == 4'hF) |=> (out_valid && out_sop && out_data[3:0] == 4'h0));

   a_r2_ctl_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && in_type == 4'hF) |-> in_ready);

   a_r6_gap_after_image: assert property (@(posedge clk) disable iff (!rst_n)
      (ofire && out_eop && (in_img || (out_sop && out_data[3:0] == 4'h0))) |=> out_gap);
endmodule

bind frame_pkt_sequencer fbseq_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_type(in_data[3:0]), .in_sop(in_sop), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
   .out_eop(out_eop), .out_gap(out_gap)
);

// File: tb/frame_pkt_sequencer_test.sv
`timescale 1ns/1ps
module frame_pkt_sequencer_test;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_drop = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_repeat = 1'b0, rdy_lvl = 1'b1, throttle = 1'b0, tog = 1'b0;
   logic        in_ready, out_valid, out_ready, out_sop, out_eop, out_gap;
   logic [15:0] out_data;

   int checks = 0, fails = 0, lg_n = 0, ex_n = 0;
   logic [15:0] lg_d [256];
   logic        lg_s [256], lg_e [256];
   logic [15:0] ex_d [256];
   logic        ex_s [256], ex_e [256];

   always #4 clk = ~clk;
   always begin @(posedge clk); #1; tog = ~tog; end
   assign out_ready = throttle ? tog : rdy_lvl;

   frame_pkt_sequencer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_drop(in_drop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop), .out_repeat(out_repeat), .out_gap(out_gap)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready && lg_n < 256) begin
         lg_d[lg_n] = out_data;
         lg_s[lg_n] = out_sop;
         lg_e[lg_n] = out_eop;
         lg_n = lg_n + 1;
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      summary();
      $finish;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sync();
      @(posedge clk); #1;
   endtask

   task automatic beat(input logic [15:0] d, input logic s, input logic e, input logic dr);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_drop = dr;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0; in_drop = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic send_pkt(input logic [3:0] typ, input logic [11:0] hi,
                           input logic [15:0] first, input int n, input logic drop);
      beat({hi, typ}, 1'b1, n == 0, drop);
      for (int i = 0; i < n; i++) beat(first + 16'(i), 1'b0, i == n - 1, drop);
   endtask

   task automatic send_ctl(input int len);
      send_pkt(4'hF, 12'h0C1, 16'(len), 1, 1'b0);
   endtask

   task automatic ex_push(input logic [15:0] d, input logic s, input logic e);
      ex_d[ex_n] = d; ex_s[ex_n] = s; ex_e[ex_n] = e; ex_n = ex_n + 1;
   endtask

   task automatic ex_user(input logic [3:0] typ, input logic [11:0] hi,
                          input logic [15:0] first, input int n);
      ex_push({hi, typ}, 1'b1, n == 0);
      for (int i = 0; i < n; i++) ex_push(first + 16'(i), 1'b0, i == n - 1);
   endtask

   task automatic ex_frame(input logic [15:0] first, input int n);
      ex_push(16'h000F, 1'b1, 1'b1);
      ex_push(16'h0000, 1'b1, n == 0);
      for (int i = 0; i < n; i++) ex_push(first + 16'(i), 1'b0, i == n - 1);
   endtask

   task automatic start_scn();
      sync();
      lg_n = 0; ex_n = 0;
   endtask

   task automatic compare(input string req);
      for (int k = 0; k < 3000 && lg_n < ex_n; k++) @(negedge clk);
      repeat (20) @(negedge clk);
      check({req, " beat count"}, lg_n, ex_n);
      for (int i = 0; i < ex_n; i++)
         check(req, {14'd0, lg_s[i], lg_e[i], lg_d[i]}, {14'd0, ex_s[i], ex_e[i], ex_d[i]});
      sync();
   endtask

   task automatic do_repeat();
      for (int k = 0; k < 3000 && !out_gap; k++) sync();
      out_repeat = 1'b1;
      sync();
      out_repeat = 1'b0;
   endtask

   // R10: reset state
   task automatic t_reset();
      @(negedge clk);
      check("R10 out_valid", out_valid, 0);
      check("R10 out_gap", out_gap, 1);
      check("R10 in_ready", in_ready, 1);
   endtask

   // R11: repeat before any frame is ignored
   task automatic t_early_repeat();
      start_scn();
      do_repeat();
      repeat (30) @(negedge clk);
      check("R11 no output beats", lg_n, 0);
      check("R11 out_valid", out_valid, 0);
      sync();
   endtask

   // R1 R2 R3 R4: control discarded, user forwarded, frame regenerated
   task automatic t_basic();
      start_scn();
      send_ctl(4);
      send_pkt(4'h3, 12'hAB1, 16'h0100, 3, 1'b0);
      send_pkt(4'h0, 12'h5A0, 16'h0200, 4, 1'b0);
      ex_user(4'h3, 12'hAB1, 16'h0100, 3);
      ex_frame(16'h0200, 4);
      compare("R1 R2 R3 R4 basic frame");
   endtask

   // R5: dropped frame, user packets carried forward
   task automatic t_drop();
      start_scn();
      send_ctl(3);
      send_pkt(4'h7, 12'h111, 16'h0300, 2, 1'b0);
      send_pkt(4'h0, 12'h000, 16'h0400, 3, 1'b1);
      send_pkt(4'h9, 12'h222, 16'h0500, 0, 1'b0);
      send_pkt(4'h0, 12'h000, 16'h0600, 3, 1'b0);
      ex_user(4'h7, 12'h111, 16'h0300, 2);
      ex_user(4'h9, 12'h222, 16'h0500, 0);
      ex_frame(16'h0600, 3);
      compare("R5 drop carry");
   endtask

   // R6: repeat resends last frame without user packets
   task automatic t_repeat();
      start_scn();
      do_repeat();
      ex_frame(16'h0600, 3);
      compare("R6 repeat");
   endtask

   // R7: length mismatch against control field drops the frame
   task automatic t_len_check();
      start_scn();
      send_ctl(5);
      send_pkt(4'h2, 12'h333, 16'h0700, 1, 1'b0);
      send_pkt(4'h0, 12'h000, 16'h0800, 3, 1'b0);
      send_pkt(4'h0, 12'h000, 16'h0900, 5, 1'b0);
      ex_user(4'h2, 12'h333, 16'h0700, 1);
      ex_frame(16'h0900, 5);
      compare("R7 length check");
   endtask

   // R8: full user queue backpressures, nothing lost
   task automatic t_user_full();
      int seen;
      start_scn();
      send_ctl(2);
      for (int p = 0; p < 4; p++) send_pkt(4'h4, 12'h444, 16'h0A80 + 16'(p), 1, 1'b0);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = {12'h555, 4'h6};
      seen = 0;
      repeat (6) begin
         @(negedge clk);
         if (in_ready) seen = seen + 1;
      end
      check("R8 in_ready while user queue full", seen, 0);
      sync();
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      send_pkt(4'h0, 12'h000, 16'h0A00, 2, 1'b0);
      for (int p = 0; p < 4; p++) ex_user(4'h4, 12'h444, 16'h0A80 + 16'(p), 1);
      ex_frame(16'h0A00, 2);
      compare("R8 user packets kept");
   endtask

   // R9: occupied spare slot stalls the next end beat
   task automatic t_spare_stall();
      start_scn();
      rdy_lvl = 1'b0;
      send_ctl(2);
      send_pkt(4'h0, 12'h000, 16'h0B00, 2, 1'b0);
      send_pkt(4'h0, 12'h000, 16'h0C00, 2, 1'b0);
      fork
         send_pkt(4'h0, 12'h000, 16'h0D00, 2, 1'b0);
         begin
            repeat (12) @(negedge clk);
            check("R9 end beat presented", in_valid && in_eop, 1);
            check("R9 in_ready stalled", in_ready, 0);
            check("R9 no beat while stalled", lg_n, 0);
            sync();
            rdy_lvl = 1'b1;
         end
      join
      ex_frame(16'h0B00, 2);
      ex_frame(16'h0C00, 2);
      ex_frame(16'h0D00, 2);
      compare("R9 frames after stall");
   endtask

   // R12: output backpressure keeps beats intact
   task automatic t_throttle();
      start_scn();
      throttle = 1'b1;
      send_ctl(6);
      send_pkt(4'h5, 12'h666, 16'h0E00, 2, 1'b0);
      send_pkt(4'h0, 12'h000, 16'h0F00, 6, 1'b0);
      ex_user(4'h5, 12'h666, 16'h0E00, 2);
      ex_frame(16'h0F00, 6);
      compare("R12 throttled output");
      throttle = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_early_repeat();
      t_basic();
      t_drop();
      t_repeat();
      t_len_check();
      t_user_full();
      t_spare_stall();
      t_throttle();
      summary();
      $finish;
   end
endmodule